// File: doc/BRIEF.md
# Conditional Card Reset Sequencer

This block generates the local reset of a plug-in card. At power-up it holds the card in reset until every qualifying condition is true: six condition flags (main supply good, host-side 3.3 V good, board selected, card-side 3.3 V good, card-side 5 V good, power enable) and a high host reset. Once all of them hold, a minimum power-up reset period is counted out. Only then is the card reset released, so it is the last output of the power-up sequence to go inactive. If any condition drops, the reset comes back at once, and the full period is counted again once everything is good.

While the card is running, the host can reset it by pulling its reset line low. Short glitches are filtered out. A low that lasts long enough starts a reset cycle. That cycle lasts at least the minimum reset period, and it lasts longer if the host keeps its line low. All inputs pass through a multi-stage synchroniser first. Both output polarities are decoded from one sequencing state.

Top module: `card_reset_sequencer`

## Requirements
- R1: While `rst_n` is low, and afterwards until a release, `card_rst_n` is 0 and `card_rst` is 1.
- R2: The reset is never released unless all six condition flags are true and `host_rst_n` is high.
- R3: When the last missing qualifier becomes true, `card_rst_n` rises exactly SYNC_STAGES+1+PURST_CYC clock edges later.
- R4: If any condition flag goes false while released, the reset is asserted exactly SYNC_STAGES+1 edges later.
- R5: After a condition dropout, release again needs a full new period: SYNC_STAGES+1+PURST_CYC edges after the conditions are restored.
- R6: While released, a host reset low that lasts fewer than QUAL_CYC clock cycles has no effect on the outputs.
- R7: A host reset low of QUAL_CYC or more cycles asserts the reset SYNC_STAGES+1+QUAL_CYC edges after the low begins.
- R8: A host-initiated reset cycle keeps the reset active for at least PURST_CYC cycles, even when the host low ends earlier.
- R9: When the host holds reset low for L cycles and L-QUAL_CYC exceeds PURST_CYC, the reset stays active for exactly L-QUAL_CYC cycles, so it ends when the synchronised host line returns high.
- R10: `card_rst` is always the complement of `card_rst_n`.
- R11: Board select is active low: `board_sel_n` = 1 alone is enough to block release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's own logic |
| main_ok | input | 1 | Main supply at or above its trip level |
| host33_ok | input | 1 | Host 3.3 V supply at or above its trip level |
| board_sel_n | input | 1 | Board select, active low |
| card33_ok | input | 1 | Card-side 3.3 V at or above its trip level |
| card50_ok | input | 1 | Card-side 5 V at or above its trip level |
| pwr_en | input | 1 | Power enable, active high |
| host_rst_n | input | 1 | Host reset request, active low, asynchronous |
| card_rst_n | output | 1 | Local card reset, active low |
| card_rst | output | 1 | Local card reset, active high |

## Verification
The hardest case to reach is the edge between a host-initiated cycle that is stretched to the minimum length and one that follows the host line. The exit depends on the period timer and on the synchronised host level at the same edge, and neither can be seen from outside. The bench sweeps the host low length one cycle at a time, from below the qualification limit to well past QUAL_CYC+PURST_CYC. For each length it computes the expected assertion cycle and the expected active width as max(PURST_CYC, L-QUAL_CYC). Near-miss qualifier patterns are covered by trying all 63 incomplete condition combinations.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
   localparam int N_COND = 6;

   typedef enum logic [1:0] {
      ST_HOLD    = 2'd0,
      ST_WAIT    = 2'd1,
      ST_RUN     = 2'd2,
      ST_STRETCH = 2'd3
   } rrs_state_e;
endpackage

// File: rtl/rrs_sync.sv
module rrs_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] stg;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/rrs_lowqual.sv
module rrs_lowqual #(
   parameter int QUAL_CYC = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_s,
   output logic qual
);
   localparam int QW = $clog2(QUAL_CYC + 1);
   localparam logic [QW-1:0] QMAX = QW'(QUAL_CYC);

   logic [QW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               low_cnt <= '0;
      else if (line_s)          low_cnt <= '0;
      else if (low_cnt != QMAX) low_cnt <= low_cnt + 1'b1;
   end

   assign qual = (low_cnt == QMAX);
endmodule

// File: rtl/rrs_timer.sv
module rrs_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic done
);
   localparam int TW = $clog2(LIMIT);
   localparam logic [TW-1:0] TLAST = TW'(LIMIT - 1);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (cnt != TLAST) cnt <= cnt + 1'b1;
   end

   assign done = (cnt == TLAST);
endmodule

// File: rtl/card_reset_sequencer.sv
module card_reset_sequencer
   import rrs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_CYC    = 10,
   parameter int PURST_CYC   = 50000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic main_ok,
   input  logic host33_ok,
   input  logic board_sel_n,
   input  logic card33_ok,
   input  logic card50_ok,
   input  logic pwr_en,
   input  logic host_rst_n,
   output logic card_rst_n,
   output logic card_rst
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (QUAL_CYC < 1) begin : g_bad_qual
      $error("QUAL_CYC must be at least 1");
   end
   if (PURST_CYC < 2) begin : g_bad_purst
      $error("PURST_CYC must be at least 2");
   end

   localparam int SW = N_COND + 1;

   logic [SW-1:0] raw_in, sync_out;
   logic          cond_ok_s, host_s, host_qual, period_done;
   rrs_state_e    state, state_nx;

   assign raw_in = {host_rst_n, pwr_en, card50_ok, card33_ok,
                    ~board_sel_n, host33_ok, main_ok};

   rrs_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
   );

   assign cond_ok_s = &sync_out[N_COND-1:0];
   assign host_s    = sync_out[N_COND];

   rrs_lowqual #(.QUAL_CYC(QUAL_CYC)) u_qual (
      .clk(clk), .rst_n(rst_n), .line_s(host_s), .qual(host_qual)
   );

   rrs_timer #(.LIMIT(PURST_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(state_nx != state), .done(period_done)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_HOLD:
            if (cond_ok_s && host_s) state_nx = ST_WAIT;
         ST_WAIT:
            if (!(cond_ok_s && host_s)) state_nx = ST_HOLD;
            else if (period_done)       state_nx = ST_RUN;
         ST_RUN:
            if (!cond_ok_s)     state_nx = ST_HOLD;
            else if (host_qual) state_nx = ST_STRETCH;
         ST_STRETCH:
            if (!cond_ok_s)                  state_nx = ST_HOLD;
            else if (period_done && host_s)  state_nx = ST_RUN;
         default: state_nx = ST_HOLD;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_HOLD;
      else        state <= state_nx;
   end

   assign card_rst_n = (state == ST_RUN);
   assign card_rst   = (state != ST_RUN);
endmodule

// File: rtl/card_reset_sequencer_chk.sv
module card_reset_sequencer_chk #(
   parameter int QUAL_CYC  = 10,
   parameter int PURST_CYC = 50000
) (
   input logic clk,
   input logic rst_n,
   input logic cond_ok_s,
   input logic host_s,
   input logic card_rst_n,
   input logic card_rst
);
   localparam int AW = $clog2(PURST_CYC + 1);
   localparam int LW = $clog2(QUAL_CYC + 1);

   logic [AW-1:0] act_len;
   logic [LW-1:0] low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_len <= '0;
         low_len <= '0;
      end else begin
         if (!card_rst)                        act_len <= '0;
         else if (act_len != AW'(PURST_CYC))   act_len <= act_len + 1'b1;
         if (host_s)                           low_len <= '0;
         else if (low_len != LW'(QUAL_CYC))    low_len <= low_len + 1'b1;
      end
   end

   // R2
   release_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_rst_n) |-> ($past(cond_ok_s) && $past(host_s)));

   // R8
   min_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_rst_n) |-> (act_len >= AW'(PURST_CYC)));

   // R4
   cond_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cond_ok_s |=> card_rst);

   // R6
   glitch_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (card_rst_n && cond_ok_s && (low_len < LW'(QUAL_CYC))) |=> card_rst_n);

   // R9
   host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (card_rst && !host_s) |=> card_rst);
endmodule

bind card_reset_sequencer card_reset_sequencer_chk #(
   .QUAL_CYC(QUAL_CYC), .PURST_CYC(PURST_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cond_ok_s(cond_ok_s), .host_s(host_s),
   .card_rst_n(card_rst_n), .card_rst(card_rst)
);

// File: tb/card_reset_sequencer_bench.sv
module card_reset_sequencer_bench;
   localparam int SYNC  = 2;
   localparam int QUAL  = 3;
   localparam int PURST = 12;
   localparam int REL_LAT  = SYNC + 1 + PURST;
   localparam int DROP_LAT = SYNC + 1;
   localparam int FALL_LAT = SYNC + 1 + QUAL;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n, host_rst_n, card_rst_n, card_rst;
   logic [5:0] conds;   // {pwr_en, card50, card33, board selected, host33, main}
   int total = 0, bad = 0;

   card_reset_sequencer #(.SYNC_STAGES(SYNC), .QUAL_CYC(QUAL), .PURST_CYC(PURST))
   u_card_reset_sequencer (
      .clk(clk), .rst_n(rst_n), .main_ok(conds[0]), .host33_ok(conds[1]),
      .board_sel_n(~conds[2]), .card33_ok(conds[3]), .card50_ok(conds[4]),
      .pwr_en(conds[5]), .host_rst_n(host_rst_n),
      .card_rst_n(card_rst_n), .card_rst(card_rst)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // R10 at every sample point
   always @(negedge clk)
      if (rst_n === 1'b1)
         check(card_rst === ~card_rst_n, "R10 complement", card_rst, !card_rst_n);

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wait_level(input logic lvl, output int k);
      k = -1;
      for (int i = 1; i <= 4 * REL_LAT; i++) begin
         step();
         if (card_rst_n === lvl) begin k = i; return; end
      end
   endtask

   task automatic host_pulse(input int len);
      int first = -1, width = 0, exp_w;
      host_rst_n = 1'b0;
      for (int k = 1; k <= len + QUAL + PURST + 8; k++) begin
         step();
         if (k == len) host_rst_n = 1'b1;
         if (card_rst) begin
            if (first < 0) first = k;
            width++;
         end
      end
      if (len < QUAL) begin
         check(width == 0, "R6 short low ignored", width, 0);
      end else begin
         exp_w = (len - QUAL > PURST) ? len - QUAL : PURST;
         check(first == FALL_LAT, "R7 assert latency", first, FALL_LAT);
         if (len - QUAL > PURST) check(width == exp_w, "R9 follows host", width, exp_w);
         else                    check(width == exp_w, "R8 stretched", width, exp_w);
      end
   endtask

   initial begin
      int k;
      bit seen;
      rst_n = 1'b0; conds = '0; host_rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(card_rst_n === 1'b0 && card_rst === 1'b1, "R1 in reset", card_rst_n, 0);
      rst_n = 1'b1;
      step();
      check(card_rst_n === 1'b0, "R1 after reset", card_rst_n, 0);

      for (int c = 0; c < 63; c++) begin
         conds = 6'(c);
         seen = 1'b0;
         repeat (REL_LAT + 4) begin
            step();
            if (card_rst_n) seen = 1'b1;
         end
         if (c == 59) check(!seen, "R11 board not selected", seen, 0);
         else         check(!seen, "R2 incomplete", seen, 0);
      end

      host_rst_n = 1'b0;
      conds = 6'h3f;
      seen = 1'b0;
      repeat (REL_LAT + 4) begin
         step();
         if (card_rst_n) seen = 1'b1;
      end
      check(!seen, "R2 host low", seen, 0);
      host_rst_n = 1'b1;
      wait_level(1'b1, k);
      check(k == REL_LAT, "R3 release latency", k, REL_LAT);

      for (int b = 0; b < 6; b++) begin
         conds[b] = 1'b0;
         wait_level(1'b0, k);
         check(k == DROP_LAT, "R4 drop latency", k, DROP_LAT);
         repeat (3) step();
         conds[b] = 1'b1;
         wait_level(1'b1, k);
         check(k == REL_LAT, "R5 new period", k, REL_LAT);
      end

      for (int len = 1; len <= 30; len++) host_pulse(len);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule